// File: doc/BRIEF.md
# NAND Page and Random-Column Read Sequencer

This block reads from an 8-bit asynchronous NAND flash on behalf of a host. A request on a valid/ready command port starts one of two operations.

A page read sends the open command, five address bytes and the confirm command. It then waits until the device reports ready and streams bytes from the requested column.

A column jump sends a short command that moves the device's column pointer inside the page already held in its page register. The array is not read again. Data then streams from the new column.

Bytes leave on a valid/ready stream, each one fetched by a single read-enable pulse. All bus timing is counted in clock cycles set by parameters.

The block remembers whether a page has been loaded. It refuses a column jump when no page has been loaded. It stops any transfer at the end of the page.

Top module: `nand_page_reader`

## Requirements
- R1: A page read drives, on successive write-enable pulses, a command byte 00h with the command latch high; then five address bytes with the address latch high, in the order column low, column high, row bits 7:0, row bits 15:8, row bits 23:16; then a command byte 30h.
- R2: Each command or address byte is presented with write-enable low for exactly T_SETUP cycles. Write-enable then stays high for at least T_HOLD cycles before the next byte. The device latches the byte on the rising edge.
- R3: After 30h the sequencer waits T_WB cycles and then holds read-enable high until the ready/busy input is high. Read-enable is never low while ready/busy is low.
- R4: The first read-enable falling edge comes at least T_WHR cycles after ready/busy is seen high, or after the E0h byte of a column jump.
- R5: Each read-enable pulse yields the next sequential page byte. Bytes appear on the stream in column order. A byte offered and not accepted stays unchanged.
- R6: A column jump (cmd_random = 1) drives command 05h, the column low and column high address bytes, and command E0h. Data then starts at the new column of the loaded page.
- R7: A column jump requested while no page is loaded is accepted, pulses err_nopage one cycle later, and produces no bus activity and no stream data.
- R8: Any number of column jumps may follow one page read without reloading the page.
- R9: A request whose count runs past column PAGE_BYTES-1 delivers only the bytes up to the page end. It then pulses err_overrun together with done.
- R10: done pulses for one cycle after the last byte is accepted. A count of zero completes with done and no read-enable pulse.
- R11: After reset the block is idle: cmd_ready = 1, write-enable and read-enable high, both latch enables low, no stream data, and no page loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request offered |
| cmd_ready | output | 1 | Sequencer idle, request accepted |
| cmd_random | input | 1 | 0 = page read, 1 = column jump |
| cmd_row | input | ROW_W | Page row address (page read only) |
| cmd_col | input | COL_W | Starting column |
| cmd_len | input | LEN_W | Number of bytes wanted |
| rd_valid | output | 1 | Stream byte available |
| rd_ready | input | 1 | Stream consumer accepts |
| rd_data | output | 8 | Stream byte |
| done | output | 1 | Request finished (pulse) |
| err_nopage | output | 1 | Column jump refused, no page loaded (pulse) |
| err_overrun | output | 1 | Count truncated at page end (pulse) |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write enable, active low |
| nf_re_n | output | 1 | Read enable, active low |
| nf_rb_n | input | 1 | Ready (1) / busy (0) |
| nf_dq_o | output | 8 | Bus byte driven to the device |
| nf_dq_oe | output | 1 | Enable for nf_dq_o |
| nf_dq_i | input | 8 | Bus byte returned by the device |

## Verification
The hardest state to reach is a column jump that starts near the page end while the consumer stalls at random. In that case truncation, the column pointer and stream backpressure all interact. A jump with no loaded page is also hard to reach, since it is only possible before the first page read after reset.

The stimulus sends a jump straight out of reset. It then loads a page and chains several jumps on it, one of them two bytes short of the end with a larger count. A later page read starts at a column close to the end. Throughout, a behavioural device model checks each latched byte and each read-enable edge against queues of expected traffic.

// File: rtl/nand_page_reader.sv
module nand_page_reader #(
  parameter int PAGE_BYTES = 2112,
  parameter int COL_W      = 12,
  parameter int ROW_W      = 24,
  parameter int LEN_W      = 12,
  parameter int T_SETUP    = 2,
  parameter int T_HOLD     = 2,
  parameter int T_WB       = 4,
  parameter int T_WHR      = 6,
  parameter int T_RE_LO    = 2,
  parameter int T_RE_HI    = 2,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_random,
  input  logic [ROW_W-1:0] cmd_row,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [LEN_W-1:0] cmd_len,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             err_nopage,
  output logic             err_overrun,
  output logic             nf_cle,
  output logic             nf_ale,
  output logic             nf_we_n,
  output logic             nf_re_n,
  input  logic             nf_rb_n,
  output logic [7:0]       nf_dq_o,
  output logic             nf_dq_oe,
  input  logic [7:0]       nf_dq_i
);

  localparam logic [CNT_W-1:0] SETUP_C  = CNT_W'(T_SETUP);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(T_SETUP + T_HOLD - 1);
  localparam logic [CNT_W-1:0] WB_END   = CNT_W'(T_WB - 1);
  localparam logic [CNT_W-1:0] WHR_END  = CNT_W'(T_WHR - 1);
  localparam logic [CNT_W-1:0] RLO_END  = CNT_W'(T_RE_LO - 1);
  localparam logic [CNT_W-1:0] RHI_END  = CNT_W'(T_RE_HI - 1);

  typedef enum logic [2:0] {S_IDLE, S_BUS, S_WB, S_BUSY, S_GAP, S_RLO, S_OUT, S_RHI} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       idx;
  logic             rnd_q, ovf_q, page_ok;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [LEN_W-1:0] rem_q;
  logic [7:0]       dat_q;
  logic             done_q, nopg_q, ovr_q;

  logic [15:0]      col16;
  logic [23:0]      row24;
  logic             seq_cmd;
  logic [7:0]       seq_byte;
  logic [2:0]       last_idx;
  logic [31:0]      avail, len32;
  logic             ovf_next;
  logic [LEN_W-1:0] rem_next;

  assign col16    = 16'(col_q);
  assign row24    = 24'(row_q);
  assign last_idx = rnd_q ? 3'd3 : 3'd6;

  always_comb begin
    seq_cmd  = 1'b0;
    seq_byte = 8'h00;
    if (!rnd_q) begin
      case (idx)
        3'd0: begin seq_cmd = 1'b1; seq_byte = 8'h00; end
        3'd1: seq_byte = col16[7:0];
        3'd2: seq_byte = col16[15:8];
        3'd3: seq_byte = row24[7:0];
        3'd4: seq_byte = row24[15:8];
        3'd5: seq_byte = row24[23:16];
        default: begin seq_cmd = 1'b1; seq_byte = 8'h30; end
      endcase
    end else begin
      case (idx)
        3'd0: begin seq_cmd = 1'b1; seq_byte = 8'h05; end
        3'd1: seq_byte = col16[7:0];
        3'd2: seq_byte = col16[15:8];
        default: begin seq_cmd = 1'b1; seq_byte = 8'hE0; end
      endcase
    end
  end

  always_comb begin
    avail    = (32'(cmd_col) < 32'(PAGE_BYTES)) ? 32'(PAGE_BYTES) - 32'(cmd_col) : 32'd0;
    len32    = 32'(cmd_len);
    ovf_next = len32 > avail;
    rem_next = LEN_W'(ovf_next ? avail : len32);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; idx <= '0; rnd_q <= 1'b0; ovf_q <= 1'b0; page_ok <= 1'b0;
      row_q <= '0; col_q <= '0; rem_q <= '0; dat_q <= '0;
      done_q <= 1'b0; nopg_q <= 1'b0; ovr_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      nopg_q <= 1'b0;
      ovr_q  <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          if (cmd_random && !page_ok) nopg_q <= 1'b1;
          else begin
            rnd_q <= cmd_random;
            if (!cmd_random) begin row_q <= cmd_row; page_ok <= 1'b0; end
            col_q <= cmd_col;
            rem_q <= rem_next;
            ovf_q <= ovf_next;
            idx   <= '0;
            cnt   <= '0;
            st    <= S_BUS;
          end
        end
        S_BUS: if (cnt == BYTE_END) begin
          cnt <= '0;
          if (idx == last_idx) st <= rnd_q ? S_GAP : S_WB;
          else idx <= idx + 3'd1;
        end else cnt <= cnt + 1'b1;
        S_WB: if (cnt == WB_END) begin cnt <= '0; st <= S_BUSY; end
              else cnt <= cnt + 1'b1;
        S_BUSY: if (nf_rb_n) begin page_ok <= 1'b1; st <= S_GAP; end
        S_GAP: if (cnt == WHR_END) begin
          cnt <= '0;
          if (rem_q == '0) begin st <= S_IDLE; done_q <= 1'b1; ovr_q <= ovf_q; end
          else st <= S_RLO;
        end else cnt <= cnt + 1'b1;
        S_RLO: if (cnt == RLO_END) begin cnt <= '0; dat_q <= nf_dq_i; st <= S_OUT; end
               else cnt <= cnt + 1'b1;
        S_OUT: if (rd_ready) begin
          col_q <= col_q + 1'b1;
          rem_q <= rem_q - 1'b1;
          if (rem_q == LEN_W'(1)) begin st <= S_IDLE; done_q <= 1'b1; ovr_q <= ovf_q; end
          else st <= S_RHI;
        end
        S_RHI: if (cnt == RHI_END) begin cnt <= '0; st <= S_RLO; end
               else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready   = (st == S_IDLE);
  assign nf_we_n     = !(st == S_BUS && cnt < SETUP_C);
  assign nf_cle      = (st == S_BUS) && seq_cmd;
  assign nf_ale      = (st == S_BUS) && !seq_cmd;
  assign nf_dq_oe    = (st == S_BUS);
  assign nf_dq_o     = seq_byte;
  assign nf_re_n     = (st != S_RLO);
  assign rd_valid    = (st == S_OUT);
  assign rd_data     = dat_q;
  assign done        = done_q;
  assign err_nopage  = nopg_q;
  assign err_overrun = ovr_q;

  // R3
  re_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_re_n |-> nf_rb_n);
  // R7
  nopage_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_random && !page_ok) |=> (cmd_ready && nf_we_n && !nf_dq_oe));
  // R5
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  // R2
  we_latch_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nf_we_n) |-> (nf_cle ^ nf_ale));
  // R9
  col_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (32'(col_q) < 32'(PAGE_BYTES)));
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_ready && !rd_valid && nf_re_n));

endmodule

// File: tb/tb_nand_page_reader.sv
module tb_nand_page_reader;
  localparam int PAGE = 2112;
  localparam int T_SETUP = 2, T_HOLD = 2, T_WB = 4, T_WHR = 6;
  localparam int BUSY_CY = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_random = 1'b0, rd_ready = 1'b1;
  logic [23:0] cmd_row = '0;
  logic [11:0] cmd_col = '0, cmd_len = '0;
  logic cmd_ready, rd_valid, done, err_nopage, err_overrun;
  logic [7:0] rd_data, nf_dq_o;
  logic nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
  logic nf_rb_n = 1'b1;
  logic [7:0] nf_dq_i = '0;

  always #5 clk = ~clk;

  nand_page_reader #(.PAGE_BYTES(PAGE), .T_SETUP(T_SETUP), .T_HOLD(T_HOLD),
                     .T_WB(T_WB), .T_WHR(T_WHR)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_random(cmd_random), .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_len(cmd_len),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .done(done),
    .err_nopage(err_nopage), .err_overrun(err_overrun), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_rb_n(nf_rb_n), .nf_dq_o(nf_dq_o),
    .nf_dq_oe(nf_dq_oe), .nf_dq_i(nf_dq_i));

  int vecs = 0, errs = 0;
  bit finished = 0;
  logic [9:0] exp_bus[$];
  logic [7:0] exp_dat[$];
  int abuf[$];
  int m_row = 0, m_ptr = 0, busy_left = 0, cur_row = 0;
  int we_lo = 0, we_hi = 100, since_rdy = 0, since_e0 = 0, bus_events = 0, re_falls = 0;
  bit first_pend = 0, first_e0 = 0, bp = 0;
  logic prev_we = 1'b1, prev_re = 1'b1;

  function automatic logic [7:0] pdat(int row, int col);
    return 8'(row * 5 + col * 7 + (col >> 8) + 60);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    rd_ready = !bp || (($urandom % 3) != 0);
    if (nf_cle && nf_ale) chk(0, "R1", 3, 1);
    if (busy_left > 0) begin
      busy_left--;
      if (busy_left == 0) nf_rb_n = 1'b1;
    end
    if (nf_rb_n) since_rdy++; else since_rdy = 0;
    since_e0++;
    if (!nf_we_n) we_lo++; else we_hi++;
    if (prev_we && !nf_we_n) begin
      chk(we_hi >= T_HOLD, "R2", we_hi, T_HOLD);
      we_hi = 0;
    end
    if (!prev_we && nf_we_n) begin
      bus_events++;
      chk(we_lo == T_SETUP, "R2", we_lo, T_SETUP);
      we_lo = 0;
      we_hi = 1;
      if (exp_bus.size() == 0) chk(0, "R1", {nf_cle, nf_ale, nf_dq_o}, 0);
      else begin
        logic [9:0] e;
        e = exp_bus.pop_front();
        chk({nf_cle, nf_ale, nf_dq_o} == e, "R1", {nf_cle, nf_ale, nf_dq_o}, e);
      end
      if (nf_cle) begin
        if (nf_dq_o == 8'h00 || nf_dq_o == 8'h05) abuf.delete();
        else if (nf_dq_o == 8'h30 && abuf.size() == 5) begin
          m_ptr = abuf[0] | (abuf[1] << 8);
          m_row = abuf[2] | (abuf[3] << 8) | (abuf[4] << 16);
          nf_rb_n = 1'b0;
          busy_left = BUSY_CY;
          first_pend = 1; first_e0 = 0;
        end else if (nf_dq_o == 8'hE0 && abuf.size() == 2) begin
          m_ptr = abuf[0] | (abuf[1] << 8);
          since_e0 = 0;
          first_pend = 1; first_e0 = 1;
        end
      end else abuf.push_back(int'(nf_dq_o));
    end
    if (prev_re && !nf_re_n) begin
      re_falls++;
      chk(nf_rb_n == 1'b1, "R3", nf_rb_n, 1);
      if (first_pend) begin
        chk((first_e0 ? since_e0 : since_rdy) >= T_WHR, "R4",
            first_e0 ? since_e0 : since_rdy, T_WHR);
        first_pend = 0;
      end
      nf_dq_i = pdat(m_row, m_ptr);
    end
    if (!prev_re && nf_re_n) m_ptr++;
    if (rd_valid && exp_dat.size() == 0) chk(0, "R5", rd_data, 0);
    if (rd_valid && rd_ready && exp_dat.size() != 0) begin
      logic [7:0] d;
      d = exp_dat.pop_front();
      chk(rd_data == d, "R5", rd_data, d);
    end
    prev_we = nf_we_n;
    prev_re = nf_re_n;
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  task automatic issue(bit rnd, int row, int col, int len, string req);
    int n, ev0, re0, t;
    bit ovf, got;
    ev0 = bus_events; re0 = re_falls;
    if (!rnd) cur_row = row;
    n = (col < PAGE) ? PAGE - col : 0;
    ovf = len > n;
    if (!ovf) n = len;
    if (!rnd) begin
      exp_bus.push_back({2'b10, 8'h00});
      exp_bus.push_back({2'b01, 8'(col)});
      exp_bus.push_back({2'b01, 8'(col >> 8)});
      exp_bus.push_back({2'b01, 8'(row)});
      exp_bus.push_back({2'b01, 8'(row >> 8)});
      exp_bus.push_back({2'b01, 8'(row >> 16)});
      exp_bus.push_back({2'b10, 8'h30});
    end else begin
      exp_bus.push_back({2'b10, 8'h05});
      exp_bus.push_back({2'b01, 8'(col)});
      exp_bus.push_back({2'b01, 8'(col >> 8)});
      exp_bus.push_back({2'b10, 8'hE0});
    end
    for (int i = 0; i < n; i++) exp_dat.push_back(pdat(cur_row, col + i));
    while (!cmd_ready) @(negedge clk);
    cmd_random = rnd; cmd_row = 24'(row); cmd_col = 12'(col); cmd_len = 12'(len);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    got = 0; t = 0;
    while (!got && t < 20000) begin
      @(negedge clk);
      t++;
      if (done) begin
        got = 1;
        chk(err_overrun == ovf, "R9", err_overrun, ovf);
      end
    end
    chk(got, "R10", got, 1);
    chk(exp_dat.size() == 0, req, exp_dat.size(), 0);
    chk(exp_bus.size() == 0, rnd ? "R6" : "R1", exp_bus.size(), 0);
    if (len == 0) chk(re_falls == re0, "R10", re_falls - re0, 0);
    if (rnd) chk(bus_events - ev0 == 4, "R6", bus_events - ev0, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(cmd_ready && nf_we_n && nf_re_n && !nf_cle && !nf_ale && !rd_valid && !done,
        "R11", {cmd_ready, nf_we_n, nf_re_n, nf_cle, nf_ale, rd_valid}, 6'b111000);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 column jump with no page loaded
    begin
      int ev0;
      ev0 = bus_events;
      cmd_random = 1'b1; cmd_col = 12'd4; cmd_len = 12'd3; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(err_nopage == 1'b1, "R7", err_nopage, 1);
      repeat (20) @(negedge clk);
      chk(bus_events == ev0 && re_falls == 0, "R7", bus_events - ev0 + re_falls, 0);
      chk(cmd_ready && !rd_valid, "R7", {cmd_ready, rd_valid}, 2'b10);
    end
    issue(0, 24'h012345, 16, 8, "R5");
    bp = 1;
    issue(1, 0, 12'h700, 5, "R6");
    issue(1, 0, 3, 4, "R8");
    issue(1, 0, PAGE - 2, 6, "R9");
    issue(1, 0, 5, 0, "R10");
    issue(0, 24'h000abc, PAGE - 12, 20, "R9");
    bp = 0;
    issue(1, 0, 0, 3, "R8");
    issue(1, 0, 1000, 16, "R5");
    repeat (5) @(negedge clk);
    finish_run();
  end

  initial begin
    #(150000 * 10);
    vecs++; errs++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end
endmodule